// File: doc/BRIEF.md
# HUB75E Panel Scan Driver

This block refreshes one 64x64 RGB LED matrix over a HUB75E style connector. It reads pixels from the read side of a dual-port framebuffer, where each pixel is a word of three 6-bit channels. Each channel code goes through a hardware gamma curve that turns it into an 8-bit intensity. The block then shows the picture one row pair at a time, using binary-coded modulation over eight bit-planes. The panel uses 1/32 scan, so every shifted column carries one pixel from the upper half and one from the lower half. The lower-half pixel sits 32 rows below the upper one.

For each row pair and bit-plane, the block clocks out one line of bits with the panel dark. It then pulses the latch, presents the new row address, and lights the panel for a time proportional to the plane's weight. A 7-bit global brightness value scales that lit time. The block also watches write activity on the framebuffer. If no pixel is written for a programmable number of clocks, it switches to a generated test picture. The first write after that switches it back to framebuffer content.

Top module: `hub75_scan`

## Requirements
- R1: While reset is held and right after it is released, `oe_n` is 1, `latch` is 0, `sclk` is 0, `row_addr` is 0 and both colour outputs are 0. The block leaves reset showing the test picture.
- R2: Each line clocks out exactly COLS rising edges of `sclk`, followed by one `latch` pulse. `oe_n` stays 1 during every `sclk` pulse and during the latch.
- R3: A pixel word is {red[17:12], green[11:6], blue[5:0]}. A channel code v maps to intensity floor((255*v*v + 1984) / 3969). While plane k is clocked out, each colour output is {red, green, blue} at bits 2..0, and each bit is bit k of that channel's intensity.
- R4: For row pair r, column c is read at `rd_row` = r, `rd_col` = c, with one clock of read latency. `px_top` supplies row r, shown on `up_rgb`. `px_bot` supplies row r+HALF, shown on `lo_rgb`.
- R5: `row_addr` changes only at the end of the latch cycle. In the cycle after the latch it already equals the row pair just shifted, and `oe_n` is still 1. It stays constant while `oe_n` is 0.
- R6: Planes run in the order 0 to 7 within a row pair. Row pairs advance by one after plane 7 and wrap from HALF-1 to 0.
- R7: The distance from one latch to the next is 2*COLS + 4 + UNIT*2^k clocks, where k is the plane latched first.
- R8: After the latch of plane k, `oe_n` is 0 for floor(UNIT*2^k*B/128) clocks, where B is `bri` sampled in the latch cycle. B = 0 keeps the panel dark.
- R9: TIMEOUT clocks after the last `fb_wr` pulse, the block shows the test picture instead of the framebuffer.
- R10: An `fb_wr` pulse selects framebuffer content from the next clock on.
- R11: In the test picture, the pixel at full row y and column x has red = x, green = y and blue = x XOR y, each taken to 6 bits. It then goes through the same gamma and plane path as framebuffer pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_wr | input | 1 | Pulse for every framebuffer write (activity) |
| px_top | input | 18 | Read data, upper-half pixel |
| px_bot | input | 18 | Read data, lower-half pixel |
| bri | input | 7 | Global brightness |
| rd_row | output | 5 | Framebuffer read row pair |
| rd_col | output | 6 | Framebuffer read column |
| up_rgb | output | 3 | Upper-half colour bits {R,G,B} |
| lo_rgb | output | 3 | Lower-half colour bits {R,G,B} |
| row_addr | output | 5 | Panel row address |
| sclk | output | 1 | Column shift clock |
| latch | output | 1 | Line latch strobe |
| oe_n | output | 1 | Output enable, active low |

## Verification
A wrong row or plane counter shows up at the very next latch. The line just clocked out no longer matches bit k of the gamma intensities for the expected row pair. The latch-to-latch distance and the lit-clock count also stop matching the expected plane weight, so a counter fault is caught within one plane period. A faulty gamma entry or channel ordering corrupts the captured bits of the line that uses that code, and the bench sweeps all 64 codes in every plane. A faulty activity timer shows up only when the source changes: after the idle window, lines still carry framebuffer data where the test picture is expected, or the reverse after a write.

// File: rtl/hub75_scan_pkg.sv
package hub75_scan_pkg;

  typedef enum logic [1:0] {
    ST_SHIFT  = 2'd0,
    ST_LATCH  = 2'd1,
    ST_ROWSET = 2'd2,
    ST_SHOW   = 2'd3
  } scan_st_t;

  // Squared-law curve with rounding: out = round(omax * (v / imax)^2)
  function automatic int unsigned gamma_map(int unsigned v, int unsigned in_w,
                                            int unsigned out_w);
    int unsigned imax;
    int unsigned omax;
    imax = (1 << in_w) - 1;
    omax = (1 << out_w) - 1;
    return (omax * v * v + (imax * imax) / 2) / (imax * imax);
  endfunction

endpackage

// File: rtl/hub75_scan_gamma.sv
module hub75_scan_gamma
  import hub75_scan_pkg::*;
#(
  parameter int IN_W  = 6,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  code,
  output logic [OUT_W-1:0] level
);
  localparam int ENTRIES = 1 << IN_W;

  logic [OUT_W-1:0] lut [ENTRIES];

  for (genvar v = 0; v < ENTRIES; v++) begin : g_lut
    localparam logic [OUT_W-1:0] LVL = OUT_W'(gamma_map(v, IN_W, OUT_W));
    assign lut[v] = LVL;
  end

  assign level = lut[code];

endmodule

// File: rtl/hub75_scan_idle.sv
module hub75_scan_idle #(
  parameter int TIMEOUT = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  output logic test_mode
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] idle_q, idle_d;
  logic          test_q, test_d;

  always_comb begin
    idle_d = idle_q;
    test_d = test_q;
    if (wr) begin
      idle_d = TW'(TIMEOUT);
      test_d = 1'b0;
    end else if (idle_q != '0) begin
      idle_d = idle_q - 1'b1;
      if (idle_q == TW'(1)) test_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      test_q <= 1'b1;
    end else begin
      idle_q <= idle_d;
      test_q <= test_d;
    end
  end

  assign test_mode = test_q;

endmodule

// File: rtl/hub75_scan_seq.sv
module hub75_scan_seq
  import hub75_scan_pkg::*;
#(
  parameter int COLS   = 64,
  parameter int ROW_AW = 5,
  parameter int PLANES = 8,
  parameter int BRI_W  = 7,
  parameter int UNIT   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BRI_W-1:0]          bri,
  output logic [$clog2(COLS)-1:0]   col,
  output logic [ROW_AW-1:0]         row,
  output logic [$clog2(PLANES)-1:0] plane,
  output logic                      cap_en,
  output logic                      sclk,
  output logic                      latch,
  output logic                      oe_n,
  output logic [ROW_AW-1:0]         row_addr,
  output logic [BRI_W-1:0]          bri_lat
);
  localparam int CAW     = $clog2(COLS);
  localparam int PLW     = $clog2(PLANES);
  localparam int SH_MAX  = 2 * COLS + 1;
  localparam int PER_MAX = UNIT << (PLANES - 1);
  localparam int CNTW    = $clog2((SH_MAX > PER_MAX ? SH_MAX : PER_MAX) + 1);
  localparam int PRW     = CNTW + BRI_W;
  localparam logic [CNTW-1:0] SHIFT_LAST = CNTW'(SH_MAX);
  localparam logic [CNTW-1:0] CAP_END    = CNTW'(2 * COLS);
  localparam logic [PLW-1:0]  PL_LAST    = PLW'(PLANES - 1);

  scan_st_t          st_q, st_d;
  logic [CNTW-1:0]   cnt_q, cnt_d;
  logic [ROW_AW-1:0] row_q, row_d;
  logic [PLW-1:0]    pl_q, pl_d;
  logic [ROW_AW-1:0] addr_q, addr_d;
  logic [BRI_W-1:0]  bri_q, bri_d;

  logic [CNTW-1:0]   period;
  logic [PRW-1:0]    prod;
  logic [CNTW-1:0]   on_time;

  assign period  = CNTW'(UNIT) << pl_q;
  assign prod    = PRW'(period) * PRW'(bri_q);
  assign on_time = CNTW'(prod >> BRI_W);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    row_d  = row_q;
    pl_d   = pl_q;
    addr_d = addr_q;
    bri_d  = bri_q;
    unique case (st_q)
      ST_SHIFT: begin
        if (cnt_q == SHIFT_LAST) begin
          st_d  = ST_LATCH;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LATCH: begin
        st_d   = ST_ROWSET;
        addr_d = row_q;
        bri_d  = bri;
      end
      ST_ROWSET: begin
        st_d  = ST_SHOW;
        cnt_d = '0;
      end
      ST_SHOW: begin
        if (cnt_q == period - 1'b1) begin
          st_d  = ST_SHIFT;
          cnt_d = '0;
          if (pl_q == PL_LAST) begin
            pl_d  = '0;
            row_d = row_q + 1'b1;
          end else begin
            pl_d = pl_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_SHIFT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SHIFT;
      cnt_q  <= '0;
      row_q  <= '0;
      pl_q   <= '0;
      addr_q <= '0;
      bri_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      row_q  <= row_d;
      pl_q   <= pl_d;
      addr_q <= addr_d;
      bri_q  <= bri_d;
    end
  end

  // Moore decode of the strobes from registered state
  assign col      = cnt_q[CAW:1];
  assign row      = row_q;
  assign plane    = pl_q;
  assign cap_en   = (st_q == ST_SHIFT) && cnt_q[0] && (cnt_q < CAP_END);
  assign sclk     = (st_q == ST_SHIFT) && cnt_q[0] && (cnt_q >= CNTW'(3));
  assign latch    = (st_q == ST_LATCH);
  assign oe_n     = !((st_q == ST_SHOW) && (cnt_q < on_time));
  assign row_addr = addr_q;
  assign bri_lat  = bri_q;

endmodule

// File: rtl/hub75_scan.sv
module hub75_scan
  import hub75_scan_pkg::*;
#(
  parameter int COLS    = 64,
  parameter int ROW_AW  = 5,
  parameter int CHAN_W  = 6,
  parameter int GAMMA_W = 8,
  parameter int BRI_W   = 7,
  parameter int UNIT    = 4,
  parameter int TIMEOUT = 25_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fb_wr,
  input  logic [3*CHAN_W-1:0]     px_top,
  input  logic [3*CHAN_W-1:0]     px_bot,
  input  logic [BRI_W-1:0]        bri,
  output logic [ROW_AW-1:0]       rd_row,
  output logic [$clog2(COLS)-1:0] rd_col,
  output logic [2:0]              up_rgb,
  output logic [2:0]              lo_rgb,
  output logic [ROW_AW-1:0]       row_addr,
  output logic                    sclk,
  output logic                    latch,
  output logic                    oe_n
);
  localparam int CAW = $clog2(COLS);
  localparam int PXW = 3 * CHAN_W;
  localparam int PLW = $clog2(GAMMA_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic [CAW-1:0]    col;
  logic [ROW_AW-1:0] row;
  logic [PLW-1:0]    plane;
  logic              cap_en;
  logic              test_mode;
  logic [BRI_W-1:0]  bri_lat;

  hub75_scan_seq #(
    .COLS  (COLS),
    .ROW_AW(ROW_AW),
    .PLANES(GAMMA_W),
    .BRI_W (BRI_W),
    .UNIT  (UNIT)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .bri     (bri),
    .col     (col),
    .row     (row),
    .plane   (plane),
    .cap_en  (cap_en),
    .sclk    (sclk),
    .latch   (latch),
    .oe_n    (oe_n),
    .row_addr(row_addr),
    .bri_lat (bri_lat)
  );

  hub75_scan_idle #(
    .TIMEOUT(TIMEOUT)
  ) u_idle (
    .clk      (clk),
    .rst_n    (rst_ns),
    .wr       (fb_wr),
    .test_mode(test_mode)
  );

  assign rd_row = row;
  assign rd_col = col;

  logic [1:0][2:0] rgb_d;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [ROW_AW:0]  frow;
    logic [CHAN_W-1:0] tp_r, tp_g, tp_b;
    logic [PXW-1:0]   pix;

    assign frow = {(h == 1) ? 1'b1 : 1'b0, row};
    assign tp_r = CHAN_W'(col);
    assign tp_g = CHAN_W'(frow);
    assign tp_b = CHAN_W'(col) ^ CHAN_W'(frow);
    assign pix  = test_mode ? {tp_r, tp_g, tp_b} : ((h == 0) ? px_top : px_bot);

    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      logic [GAMMA_W-1:0] lvl;
      hub75_scan_gamma #(
        .IN_W (CHAN_W),
        .OUT_W(GAMMA_W)
      ) u_gam (
        .code (pix[(3-ch)*CHAN_W-1 -: CHAN_W]),
        .level(lvl)
      );
      assign rgb_d[h][2-ch] = lvl[plane];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      up_rgb <= '0;
      lo_rgb <= '0;
    end else if (cap_en) begin
      up_rgb <= rgb_d[0];
      lo_rgb <= rgb_d[1];
    end
  end

endmodule

// File: rtl/hub75_scan_chk.sv
module hub75_scan_chk #(
  parameter int ROW_AW = 5,
  parameter int BRI_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fb_wr,
  input logic              test_mode,
  input logic              latch,
  input logic              sclk,
  input logic              oe_n,
  input logic [ROW_AW-1:0] row_addr,
  input logic [BRI_W-1:0]  bri_lat
);

  p_latch_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> oe_n);

  p_shift_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> oe_n);

  p_latch_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !latch);

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && $past(!oe_n)) |-> $stable(row_addr));

  p_addr_after_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> $past(latch));

  p_dark_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bri_lat == '0) |-> oe_n);

  p_write_resumes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fb_wr |=> !test_mode);

endmodule

bind hub75_scan hub75_scan_chk #(
  .ROW_AW(ROW_AW),
  .BRI_W (BRI_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_ns),
  .fb_wr    (fb_wr),
  .test_mode(test_mode),
  .latch    (latch),
  .sclk     (sclk),
  .oe_n     (oe_n),
  .row_addr (row_addr),
  .bri_lat  (bri_lat)
);

// File: tb/sim_hub75_scan.sv
`timescale 1ns/1ps
module sim_hub75_scan;
  localparam int C   = 4;
  localparam int RAW = 2;
  localparam int H   = 1 << RAW;
  localparam int NR  = 2 * H;
  localparam int U   = 2;
  localparam int TO  = 8000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic           fb_wr;
  logic [6:0]     bri;
  logic [17:0]    px_top, px_bot;
  logic [RAW-1:0] rd_row;
  logic [1:0]     rd_col;
  logic [2:0]     up_rgb, lo_rgb;
  logic [RAW-1:0] row_addr;
  logic           sclk, latch, oe_n;

  hub75_scan #(
    .COLS(C), .ROW_AW(RAW), .CHAN_W(6), .GAMMA_W(8), .BRI_W(7),
    .UNIT(U), .TIMEOUT(TO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .fb_wr(fb_wr), .px_top(px_top), .px_bot(px_bot),
    .bri(bri), .rd_row(rd_row), .rd_col(rd_col), .up_rgb(up_rgb), .lo_rgb(lo_rgb),
    .row_addr(row_addr), .sclk(sclk), .latch(latch), .oe_n(oe_n)
  );

  logic [17:0] mem [NR][C];
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gam(input int v);
    return (255 * v * v + 1984) / 3969;
  endfunction

  function automatic logic [17:0] pat(input int y, input int x);
    logic [5:0] r, g, b;
    r = 6'(x);
    g = 6'(y);
    b = 6'(x ^ y);
    return {r, g, b};
  endfunction

  function automatic logic [2:0] bits(input logic [17:0] p, input int k);
    int gr, gg, gb;
    gr = gam(int'(p[17:12]));
    gg = gam(int'(p[11:6]));
    gb = gam(int'(p[5:0]));
    return {gr[k], gg[k], gb[k]};
  endfunction

  // framebuffer read side, one clock of latency (R4)
  always @(posedge clk) begin
    px_top <= mem[int'(rd_row)][int'(rd_col)];
    px_bot <= mem[int'(rd_row) + H][int'(rd_col)];
  end

  // activity model from R9/R10
  logic m_test;
  int   m_idle;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_test <= 1'b1;
      m_idle <= 0;
    end else if (fb_wr) begin
      m_test <= 1'b0;
      m_idle <= TO;
    end else if (m_idle != 0) begin
      m_idle <= m_idle - 1;
      if (m_idle == 1) m_test <= 1'b1;
    end
  end

  bit   mon_on = 0;
  bit   wr_flag = 0;
  int   phase = 0;
  bit   prev_sclk = 0;
  logic prev_mt = 1'b1;
  bit   dirty = 0;
  bit   have = 0;
  int   since = 100;
  int   ncap = 0;
  int   on_cnt = 0;
  int   exp_on = 0;
  int   exp_per = 0;
  int   erow = 0;
  int   eplane = 0;
  int   disp_row = 0;
  int   n_tl = 0, n_tl2 = 0, n_nl = 0, n_nl3 = 0;
  logic [2:0] cap_u [C];
  logic [2:0] cap_l [C];

  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_flag) begin dirty = 1; wr_flag = 0; end
      if (m_test !== prev_mt) dirty = 1;
      prev_mt = m_test;
      if (sclk && !prev_sclk) begin
        chk(oe_n == 1'b1, "R2 dark while shifting", oe_n, 1);
        if (ncap < C) begin
          cap_u[ncap] = up_rgb;
          cap_l[ncap] = lo_rgb;
        end
        ncap++;
      end
      prev_sclk = sclk;
      since++;
      if (!oe_n) begin
        on_cnt++;
        chk(int'(row_addr) == disp_row, "R5 address while lit", row_addr, disp_row);
      end
      if (since == 1)
        chk(int'(row_addr) == disp_row && oe_n, "R5 address before enable", row_addr, disp_row);
      if (latch) begin
        if (have) begin
          chk(since == exp_per, "R6 R7 plane period", since, exp_per);
          chk(on_cnt == exp_on, "R8 lit clocks", on_cnt, exp_on);
        end
        chk(ncap == C, "R2 shift pulses per line", ncap, C);
        if (!dirty && ncap == C) begin
          for (int x = 0; x < C; x++) begin
            logic [17:0] pu, pl;
            logic [2:0]  eu, el;
            pu = m_test ? pat(erow, x) : mem[erow][x];
            pl = m_test ? pat(erow + H, x) : mem[erow + H][x];
            eu = bits(pu, eplane);
            el = bits(pl, eplane);
            if (m_test) begin
              chk(cap_u[x] == eu, "R11 test picture upper", cap_u[x], eu);
              chk(cap_l[x] == el, "R11 test picture lower", cap_l[x], el);
            end else begin
              chk(cap_u[x] == eu, "R3 R4 upper pixel", cap_u[x], eu);
              chk(cap_l[x] == el, "R3 R4 lower pixel", cap_l[x], el);
            end
          end
          if (m_test) begin n_tl++; if (phase == 2) n_tl2++; end
          else begin n_nl++; if (phase == 3) n_nl3++; end
        end
        have = 1;
        exp_per = 2 * C + 4 + (U << eplane);
        exp_on = ((U << eplane) * int'(bri)) >> 7;
        on_cnt = 0;
        ncap = 0;
        dirty = 0;
        disp_row = erow;
        since = 0;
        eplane++;
        if (eplane == 8) begin
          eplane = 0;
          erow = (erow + 1) % H;
        end
      end
    end
  end

  task automatic load(input int sel);
    for (int y = 0; y < NR; y++) begin
      for (int x = 0; x < C; x++) begin
        int i;
        logic [5:0] r, g, b;
        i = y * C + x;
        if (sel == 0) begin
          r = 6'(i); g = 6'(i + 32); b = 6'(63 - i);
        end else begin
          r = 6'(5 * i + 7); g = 6'(i ^ 42); b = 6'(i * i);
        end
        @(posedge clk); #1;
        mem[y][x] = {r, g, b};
        fb_wr = 1'b1;
        wr_flag = 1;
      end
    end
    @(posedge clk); #1;
    fb_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    for (int y = 0; y < NR; y++)
      for (int x = 0; x < C; x++) mem[y][x] = '0;
    rst_n = 1'b0;
    fb_wr = 1'b0;
    bri = 7'd127;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(oe_n == 1'b1 && latch == 1'b0 && sclk == 1'b0, "R1 strobes in reset",
        {oe_n, latch, sclk}, 3'b100);
    chk(row_addr == '0 && up_rgb == '0 && lo_rgb == '0, "R1 data in reset",
        {row_addr, up_rgb, lo_rgb}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_on = 1;
    repeat (3) @(negedge clk);
    chk(oe_n == 1'b1 && latch == 1'b0 && row_addr == '0, "R1 after release",
        {oe_n, latch, row_addr}, 8);
    phase = 0;
    repeat (2600) @(posedge clk);
    phase = 1;
    load(0);
    repeat (2500) @(posedge clk);
    #1 bri = 7'd64;
    repeat (2500) @(posedge clk);
    #1 bri = 7'd0;
    repeat (2500) @(posedge clk);
    #1 bri = 7'd3;
    phase = 2;
    repeat (3000) @(posedge clk);
    #1 bri = 7'd127;
    repeat (6000) @(posedge clk);
    phase = 3;
    #1 bri = 7'd100;
    load(1);
    repeat (3000) @(posedge clk);
    @(negedge clk);
    chk(n_tl > 0, "R11 test picture lines checked", n_tl, 1);
    chk(n_nl > 0, "R3 framebuffer lines checked", n_nl, 1);
    chk(n_tl2 > 0, "R9 test picture after idle window", n_tl2, 1);
    chk(n_nl3 > 0, "R10 framebuffer after new writes", n_nl3, 1);
    finish_run();
  end

endmodule